// File: doc/BRIEF.md
# Trimmable Subsecond Real-Time Counter

The block keeps wall time as a 32-bit seconds count plus a 15-bit subsecond count that advances on each 32.768 kHz tick enable. Software can calibrate it with a 16-bit trim word that is neutral at 0x7FFF. The trim is honoured at only one subsecond rollover in every 64 seconds. That is the rollover where the low six bits of the seconds count go from 63 to 0. At that rollover the subsecond count is reloaded from the trim. Depending on the trim, it either replays the last few subsecond values, which slows the clock, or jumps over the first few, which speeds it up.

A seconds-plus-subseconds compare sets a sticky interrupt. Because of the trim, a value in the replayed range is reached a second time just after the adjustment, and a value in the skipped range is never reached. A sticky adjust flag records that a non-neutral trim was applied, so software can throw away timestamps that straddle the jump. A snapshot strobe copies seconds and subseconds into shadow registers on the same clock edge. Software then reads one coherent pair and does not need to read the seconds twice.

Top module: `trim_rtc`

## Requirements
- R1: After reset, seconds, subseconds, both shadow values, irq_o and adj_o read 0, the trim word is 0x7FFF and the match pair is (0, 0).
- R2: Each clock with tick_i high adds one to the subsecond count while it is below 0x7FFF. With no tick and no load, seconds and subseconds hold.
- R3: A tick at subsecond 0x7FFF adds one to seconds. If the low six bits of the seconds were not 63, the subsecond count returns to 0x0000.
- R4: A tick at subsecond 0x7FFF with seconds low bits at 63 (the trimmed rollover) and trim above 0x7FFF reloads the subseconds with 0x8000 − (trim − 0x7FFF). For example, trim 0x8002 gives 0x7FFD, 0x7FFE, 0x7FFF and then 0x0000 with seconds incremented again.
- R5: At the trimmed rollover with trim below 0x7FFF, the subseconds reload with 0x7FFF − trim. For example, trim 0x7FFC restarts at 0x0003.
- R6: At the trimmed rollover with trim equal to 0x7FFF, the subseconds reload with 0x0000 and adj_o is not set.
- R7: A seconds load writes seconds from sec_val_i and clears subseconds to 0 on the next edge, overriding a simultaneous tick.
- R8: irq_o sets one clock after the counter arrives, by tick or by load, at exactly the match seconds and subseconds. It stays set until irq_clr_i is high, and a new hit wins over a clear.
- R9: With trim 0x8002, a match at (trimmed second, 0x7FFE) fires within the replayed counts. With trim 0x7FFC, a match at (trimmed second, 0x0001) never fires.
- R10: adj_o sets at every trimmed rollover whose trim is not 0x7FFF and holds until adj_clr_i is high.
- R11: When snap_i is high, snap_sec_o and snap_sub_o take the seconds and subseconds from the same clock edge and then hold while counting continues.
- R12: A trim write changes no rollover except the trimmed one. A non-trimmed rollover after a trim write still returns to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz tick enable, one clock wide per tick |
| sec_ld_i | input | 1 | Load seconds and clear subseconds |
| sec_val_i | input | 32 | Seconds value to load |
| trim_wr_i | input | 1 | Write trim word |
| trim_val_i | input | 16 | Trim word, 0x7FFF neutral |
| match_wr_i | input | 1 | Write match pair |
| match_sec_i | input | 32 | Match seconds |
| match_sub_i | input | 15 | Match subseconds |
| irq_clr_i | input | 1 | Clear match interrupt |
| adj_clr_i | input | 1 | Clear adjust flag |
| snap_i | input | 1 | Capture coherent snapshot |
| sec_o | output | 32 | Live seconds |
| sub_o | output | 15 | Live subseconds |
| snap_sec_o | output | 32 | Shadow seconds |
| snap_sub_o | output | 15 | Shadow subseconds |
| irq_o | output | 1 | Sticky match interrupt |
| adj_o | output | 1 | Sticky trim-applied flag |

## Verification
Short counting runs after loads of different seconds values show plain counting and holding. Rollovers are then driven through with three trim words: above neutral, below neutral and exactly neutral. These separate the replay reload from the skip reload and from the unaltered restart. A rollover from 62 to 63 run with a non-neutral trim already written shows that only the low-bits-63 rollover uses the trim. Match pairs placed inside the replayed range and inside the skipped range tell a double-visit from a never-visited value. A load landing on the match pair and a clear raised on the same edge as a hit show interrupt priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned SEC_W_DEF = 32;
  localparam int unsigned SUB_W_DEF = 15;
  localparam int unsigned PER_W_DEF = 6;   // trim period = 2**PER_W seconds

  typedef struct packed {
    logic upd;        // counter changed by tick or load
    logic trim_roll;  // trimmed rollover taken this cycle
    logic trim_neut;  // trim word is neutral
  } rtc_ev_t;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W = SEC_W_DEF,
  parameter int unsigned SUB_W = SUB_W_DEF,
  parameter int unsigned PER_W = PER_W_DEF,
  localparam int unsigned TRIM_W = SUB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic [SEC_W-1:0]  ld_val_i,
  input  logic              trim_wr_i,
  input  logic [TRIM_W-1:0] trim_val_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  sub_o,
  output rtc_ev_t           ev_o
);
  localparam logic [SUB_W-1:0]  SUB_MAX  = {SUB_W{1'b1}};
  localparam logic [TRIM_W-1:0] TRIM_NEU = {1'b0, {SUB_W{1'b1}}};

  logic [SEC_W-1:0]  sec_q;
  logic [SUB_W-1:0]  sub_q;
  logic [TRIM_W-1:0] trim_q;
  logic              at_max, per_end, roll;
  logic [SUB_W-1:0]  reload;

  assign at_max  = (sub_q == SUB_MAX);
  assign per_end = &sec_q[PER_W-1:0];
  assign roll    = tick_i && at_max && !ld_i;
  // above neutral: 2**SUB_W-(trim-neutral); below: neutral-trim; both equal ~trim
  assign reload  = ~trim_q[SUB_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (ld_i) begin
      sec_q <= ld_val_i;
      sub_q <= '0;
    end else if (tick_i) begin
      if (at_max) begin
        sec_q <= sec_q + 1'b1;
        sub_q <= per_end ? reload : '0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        trim_q <= TRIM_NEU;
    else if (trim_wr_i) trim_q <= trim_val_i;
  end

  assign sec_o          = sec_q;
  assign sub_o          = sub_q;
  assign ev_o.upd       = tick_i || ld_i;
  assign ev_o.trim_roll = roll && per_end;
  assign ev_o.trim_neut = (trim_q == TRIM_NEU);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_i) |=> ($stable(sec_q) && $stable(sub_q)));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && sub_q != SUB_MAX) |=> (sub_q == $past(sub_q) + 1'b1) && $stable(sec_q));
  p_roll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && sub_q == SUB_MAX && !(&sec_q[PER_W-1:0]))
      |=> (sub_q == '0) && (sec_q == $past(sec_q) + 1'b1));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (sub_q == '0) && (sec_q == $past(ld_val_i)));
endmodule

// File: rtl/rtc_match.sv
module rtc_match
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W = SEC_W_DEF,
  parameter int unsigned SUB_W = SUB_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEC_W-1:0] msec_i,
  input  logic [SUB_W-1:0] msub_i,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic             irq_o
);
  logic [SEC_W-1:0] msec_q;
  logic [SUB_W-1:0] msub_q;
  logic             upd_q, irq_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msec_q <= '0;
      msub_q <= '0;
    end else if (wr_i) begin
      msec_q <= msec_i;
      msub_q <= msub_i;
    end
  end

  // compare only on the cycle after the counter moved, so each arrival counts once
  assign hit = upd_q && (sec_i == msec_q) && (sub_i == msub_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      upd_q <= upd_i;
      if (hit)        irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
  p_irq_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !irq_q);
  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !upd_q) |=> !irq_q);
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W = SEC_W_DEF,
  parameter int unsigned SUB_W = SUB_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snap_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  rtc_ev_t          ev_i,
  input  logic             adj_clr_i,
  output logic [SEC_W-1:0] snap_sec_o,
  output logic [SUB_W-1:0] snap_sub_o,
  output logic             adj_o
);
  logic [SEC_W-1:0] ssec_q;
  logic [SUB_W-1:0] ssub_q;
  logic             adj_q, adj_set;

  assign adj_set = ev_i.trim_roll && !ev_i.trim_neut;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssec_q <= '0;
      ssub_q <= '0;
    end else if (snap_i) begin
      ssec_q <= sec_i;
      ssub_q <= sub_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          adj_q <= 1'b0;
    else if (adj_set)     adj_q <= 1'b1;
    else if (adj_clr_i)   adj_q <= 1'b0;
  end

  assign snap_sec_o = ssec_q;
  assign snap_sub_o = ssub_q;
  assign adj_o      = adj_q;

  p_snap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (ssec_q == $past(sec_i)) && (ssub_q == $past(sub_i)));
  p_snap_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(ssec_q) && $stable(ssub_q));
  p_adj_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_q && !adj_clr_i) |=> adj_q);
  p_adj_neut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adj_q && ev_i.trim_neut) |=> !adj_q);
endmodule

// File: rtl/trim_rtc.sv
module trim_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W = SEC_W_DEF,
  parameter int unsigned SUB_W = SUB_W_DEF,
  parameter int unsigned PER_W = PER_W_DEF,
  localparam int unsigned TRIM_W = SUB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sec_ld_i,
  input  logic [SEC_W-1:0]  sec_val_i,
  input  logic              trim_wr_i,
  input  logic [TRIM_W-1:0] trim_val_i,
  input  logic              match_wr_i,
  input  logic [SEC_W-1:0]  match_sec_i,
  input  logic [SUB_W-1:0]  match_sub_i,
  input  logic              irq_clr_i,
  input  logic              adj_clr_i,
  input  logic              snap_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic [SEC_W-1:0]  snap_sec_o,
  output logic [SUB_W-1:0]  snap_sub_o,
  output logic              irq_o,
  output logic              adj_o
);
  rtc_ev_t          ev;
  logic [SEC_W-1:0] sec;
  logic [SUB_W-1:0] sub;

  rtc_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W), .PER_W(PER_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .ld_i      (sec_ld_i),
    .ld_val_i  (sec_val_i),
    .trim_wr_i,
    .trim_val_i,
    .sec_o     (sec),
    .sub_o     (sub),
    .ev_o      (ev)
  );

  rtc_match #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_match (
    .clk_i, .rst_ni,
    .wr_i   (match_wr_i),
    .msec_i (match_sec_i),
    .msub_i (match_sub_i),
    .clr_i  (irq_clr_i),
    .upd_i  (ev.upd),
    .sec_i  (sec),
    .sub_i  (sub),
    .irq_o
  );

  rtc_shadow #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_shadow (
    .clk_i, .rst_ni, .snap_i,
    .sec_i  (sec),
    .sub_i  (sub),
    .ev_i   (ev),
    .adj_clr_i,
    .snap_sec_o,
    .snap_sub_o,
    .adj_o
  );

  assign sec_o = sec;
  assign sub_o = sub;
endmodule

// File: tb/sim_trim_rtc.sv
module sim_trim_rtc;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 0, ld = 0, trim_wr = 0, m_wr = 0, irq_clr = 0, adj_clr = 0, snap = 0;
  logic [31:0] ld_val = '0, m_sec = '0;
  logic [15:0] trim_val = 16'h7FFF;
  logic [14:0] m_sub = '0;
  logic [31:0] sec, ssec;
  logic [14:0] sub, ssub;
  logic        irq, adj;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] exp_sec;
  logic [14:0] exp_sub;

  always #10 clk = ~clk;

  trim_rtc u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sec_ld_i(ld), .sec_val_i(ld_val),
    .trim_wr_i(trim_wr), .trim_val_i(trim_val), .match_wr_i(m_wr), .match_sec_i(m_sec),
    .match_sub_i(m_sub), .irq_clr_i(irq_clr), .adj_clr_i(adj_clr), .snap_i(snap),
    .sec_o(sec), .sub_o(sub), .snap_sec_o(ssec), .snap_sub_o(ssub), .irq_o(irq), .adj_o(adj)
  );

  localparam int NV = 3;
  localparam logic [31:0] V_SEC [NV] = '{32'd100, 32'd7, 32'd300};
  localparam int          V_TCK [NV] = '{0, 1000, 32767};
  localparam logic [14:0] V_SUB [NV] = '{15'd0, 15'd1000, 15'h7FFF};

  task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk) tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk) begin ld = 1'b1; ld_val = v; end
    @(negedge clk) ld = 1'b0;
  endtask

  task automatic set_trim(input logic [15:0] t);
    @(negedge clk) begin trim_wr = 1'b1; trim_val = t; end
    @(negedge clk) trim_wr = 1'b0;
  endtask

  task automatic set_match(input logic [31:0] s, input logic [14:0] ss);
    @(negedge clk) begin m_wr = 1'b1; m_sec = s; m_sub = ss; irq_clr = 1'b1; adj_clr = 1'b1; end
    @(negedge clk) begin m_wr = 1'b0; irq_clr = 1'b0; adj_clr = 1'b0; end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 195000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<195000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R1 reset state
    chk(sec == 0 && sub == 0, "R1 count", {sec, 17'd0, sub}, 0);
    chk(ssec == 0 && ssub == 0 && !irq && !adj, "R1 flags", {irq, adj}, 0);
    @(negedge clk) rst_n = 1'b1;
    set_match(32'hFFFF_0000, 15'd0);

    // R2 table of loads and tick counts
    for (int i = 0; i < NV; i++) begin
      load(V_SEC[i]);
      run(V_TCK[i]);
      chk(sec == V_SEC[i] && sub == V_SUB[i], "R2 count", {sec, 17'd0, sub}, {V_SEC[i], 17'd0, V_SUB[i]});
    end
    idle(3);
    chk(sub == 15'h7FFF && sec == 32'd300, "R2 hold", sub, 15'h7FFF);

    // R7 load wins over tick
    @(negedge clk) begin ld = 1'b1; ld_val = 32'd42; tick = 1'b1; end
    @(negedge clk) begin ld = 1'b0; tick = 1'b0; end
    chk(sec == 32'd42 && sub == 0, "R7 load", {sec, 17'd0, sub}, {32'd42, 32'd0});

    // R8 load onto match pair, clear, hit beats clear
    set_match(32'd500, 15'd0);
    load(32'd500);
    idle(1);
    chk(irq, "R8 load hit", irq, 1);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(!irq, "R8 clear", irq, 0);
    @(negedge clk) begin ld = 1'b1; ld_val = 32'd500; end
    @(negedge clk) begin ld = 1'b0; irq_clr = 1'b1; end
    @(negedge clk) irq_clr = 1'b0;
    chk(irq, "R8 hit over clear", irq, 1);

    // R11 snapshot while counting
    load(32'd9);
    run(20);
    @(negedge clk) begin exp_sec = sec; exp_sub = sub; snap = 1'b1; tick = 1'b1; end
    @(negedge clk) snap = 1'b0;
    idle(4);
    tick = 1'b0;
    chk(ssec == exp_sec && ssub == exp_sub && sub != exp_sub, "R11 snap", {ssec, 17'd0, ssub}, {exp_sec, 17'd0, exp_sub});

    // R12 R4 R9 R10 trim above neutral
    set_trim(16'h8002);
    set_match(32'd64, 15'h7FFE);
    load(32'd62);
    run(32768);
    chk(sec == 32'd63 && sub == 0 && !adj, "R12 untrimmed roll", {sec, 17'd0, sub}, {32'd63, 32'd0});
    run(32767);
    chk(sec == 32'd63 && sub == 15'h7FFF, "R2 near end", sub, 15'h7FFF);
    run(1);
    chk(sec == 32'd64 && sub == 15'h7FFD, "R4 reload", {sec, 17'd0, sub}, {32'd64, 17'd0, 15'h7FFD});
    chk(adj, "R10 adj set", adj, 1);
    chk(!irq, "R9 not yet", irq, 0);
    run(2);
    chk(sub == 15'h7FFF, "R4 replay", sub, 15'h7FFF);
    chk(irq, "R9 replay hit", irq, 1);
    run(1);
    chk(sec == 32'd65 && sub == 0, "R3 roll after replay", {sec, 17'd0, sub}, {32'd65, 32'd0});
    @(negedge clk) adj_clr = 1'b1;
    @(negedge clk) adj_clr = 1'b0;
    chk(!adj, "R10 adj clear", adj, 0);

    // R5 R9 trim below neutral
    set_trim(16'h7FFC);
    set_match(32'd64, 15'd1);
    load(32'd63);
    run(32768);
    chk(sec == 32'd64 && sub == 15'd3, "R5 reload", {sec, 17'd0, sub}, {32'd64, 32'd3});
    run(10);
    idle(2);
    chk(!irq, "R9 skipped never hit", irq, 0);
    chk(adj, "R10 adj below", adj, 1);

    // R6 neutral trim
    set_trim(16'h7FFF);
    set_match(32'hFFFF_0000, 15'd0);
    load(32'd127);
    run(32768);
    chk(sec == 32'd128 && sub == 0, "R6 neutral reload", {sec, 17'd0, sub}, {32'd128, 32'd0});
    chk(!adj, "R6 no adj", adj, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule